// File: doc/BRIEF.md
# Floating-Point Immediate Move Execution Unit

This execution unit carries out two floating-point immediate instructions. Each cycle it may be handed a 32-bit instruction word, a valid strobe, and the current 64-bit contents of the floating-point register that the instruction names as its target. The unit builds a 16-bit immediate from three separate fields of the instruction word. It recognises the two instruction forms by their extended opcode.

The "set" form treats the immediate as the upper half of a single-precision value, with the lower half zero. It writes the exact double-precision equivalent of that value. The "patch" form is a read-modify-write, in four steps. It narrows the incoming register value to single precision by bit selection, with no rounding. It overwrites the low 16 bits of that single-precision word with the immediate. It widens the result back to double precision. It then writes the result to the same register. Issuing a set followed by a patch builds any FP32 constant in a register without a data load.

Every result leaves through a registered write-back port one cycle after issue. An unrecognised word raises a one-cycle illegal-instruction pulse instead. No status or flag state is touched.

Top module: `fpimm_exec`

## Requirements
- R1: Instruction bits are numbered MSB-first. The primary opcode is `issue_instr[31:26]` and must equal 22. The target index is `issue_instr[25:21]`. The extended opcode is `issue_instr[5:1]`, with 2 selecting the set form and 3 selecting the patch form. The immediate is `{issue_instr[15:6], issue_instr[20:16], issue_instr[0]}`, with the 10-bit field most significant.
- R2: The set form writes the exact FP64 value of the FP32 word `{imm, 16'h0000}`. For example, 0x3F80 gives 0x3FF0000000000000 and 0xBFC0 gives -1.5.
- R3: FP32-to-FP64 widening adds 896 to normal exponents, keeps the fraction left-aligned, and keeps the sign of zeros.
- R4: Widening maps FP32 exponent 255 to FP64 exponent 2047 and keeps the sign and fraction bits. Infinities stay infinities and NaNs stay NaNs with the same payload.
- R5: Widening normalises FP32 subnormals exactly. For example, the word 0x00010000 gives 2^-133.
- R6: The patch form narrows the register to FP32, replaces FP32 bits [15:0] with the immediate, and writes the widened result. A set with 0x3F80 followed by a patch with 0x8000 leaves 0x3FF0100000000000.
- R7: Narrowing keeps the sign and the top 23 fraction bits and rebiases in-range exponents by -896. Magnitudes above the FP32 range become the largest finite FP32 value of the same sign. Magnitudes in the FP32 subnormal range are shifted right with the hidden bit and truncated. Smaller magnitudes become a zero of the same sign.
- R8: Narrowing maps FP64 exponent 2047 to 255. A NaN whose top 23 fraction bits are all zero gets fraction bit 22 set, so that it stays a NaN.
- R9: An accepted recognised instruction sets `wb_valid` for exactly the following cycle, with `wb_idx` equal to its target field.
- R10: A valid word with an unmatched primary or extended opcode produces no write-back and sets `illegal` for the following cycle.
- R11: A synchronous reset clears `wb_valid` and `illegal`.
- R12: A cycle without `issue_valid` leaves `wb_valid` and `illegal` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| issue_instr | input | 32 | Instruction word |
| issue_reg | input | 64 | Current contents of the target register |
| wb_valid | output | 1 | Write-back valid |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 64 | Write-back FP64 data |
| illegal | output | 1 | Unrecognised instruction, one-cycle pulse |

## Verification
Every result, whether a write-back or an illegal pulse, is due at the first rising edge after the issue cycle, and it lasts for that one cycle only. The bench drives each word on a falling edge and samples the outputs 1 ns after the next rising edge. It then drops the strobe and samples again one edge later, to confirm that both outputs have fallen. Expected data comes from exact real-number arithmetic in the bench. For truncating narrowings, hand-worked encodings are used instead.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
    localparam int INSTR_W   = 32;
    localparam int IMM_W     = 16;
    localparam int IDX_W     = 5;
    localparam int SP_W      = 32;
    localparam int DP_W      = 64;
    localparam int SP_EXP_W  = 8;
    localparam int DP_EXP_W  = 11;
    localparam int SP_FRAC_W = SP_W - SP_EXP_W - 1;
    localparam int DP_FRAC_W = DP_W - DP_EXP_W - 1;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    localparam int REBIAS    = DP_BIAS - SP_BIAS;
    localparam int SP_EMAX   = (1 << SP_EXP_W) - 2;
    localparam int DP_NORM_LO = REBIAS + 1;
    localparam int DP_NORM_HI = REBIAS + SP_EMAX;
    localparam int DP_SUB_LO  = REBIAS + 1 - SP_FRAC_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SET   = 2'd1,
        OP_PATCH = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [IMM_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic             wb_valid;
        logic [IDX_W-1:0] wb_idx;
        logic [DP_W-1:0]  wb_data;
        logic             illegal;
    } state_t;
endpackage

// File: rtl/fpimm_decode.sv
module fpimm_decode
    import fpimm_pkg::*;
#(
    parameter logic [5:0] PRI_OPC  = 6'd22,
    parameter logic [4:0] XO_SET   = 5'd2,
    parameter logic [4:0] XO_PATCH = 5'd3
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0] pri;
    logic [4:0] xo;

    always_comb begin
        pri     = instr[31:26];
        xo      = instr[5:1];
        dec.idx = instr[25:21];
        dec.imm = {instr[15:6], instr[20:16], instr[0]};
        dec.op  = OP_NONE;
        if (pri == PRI_OPC) begin
            if (xo == XO_SET)
                dec.op = OP_SET;
            else if (xo == XO_PATCH)
                dec.op = OP_PATCH;
        end
    end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
    import fpimm_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    logic                 sgn;
    logic [SP_EXP_W-1:0]  exp_s;
    logic [SP_FRAC_W-1:0] frac_s;
    logic [SP_FRAC_W-1:0] frac_n;
    logic [4:0]           msb;

    always_comb begin
        sgn    = sp[SP_W-1];
        exp_s  = sp[SP_W-2 -: SP_EXP_W];
        frac_s = sp[SP_FRAC_W-1:0];
        msb    = '0;
        for (int i = 0; i < SP_FRAC_W; i++) begin
            if (frac_s[i])
                msb = 5'(i);
        end
        frac_n = frac_s << (5'(SP_FRAC_W) - msb);
        if (exp_s == '1) begin
            dp = {sgn, {DP_EXP_W{1'b1}}, frac_s, {FRAC_PAD{1'b0}}};
        end else if (exp_s == '0) begin
            if (frac_s == '0)
                dp = {sgn, {(DP_W-1){1'b0}}};
            else
                dp = {sgn, 11'(DP_SUB_LO) + {6'b0, msb}, frac_n, {FRAC_PAD{1'b0}}};
        end else begin
            dp = {sgn, {3'b0, exp_s} + 11'(REBIAS), frac_s, {FRAC_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
    import fpimm_pkg::*;
(
    input  logic [DP_W-1:0] dp,
    output logic [SP_W-1:0] sp
);
    logic                 sgn;
    logic [DP_EXP_W-1:0]  exp_d;
    logic [DP_FRAC_W-1:0] frac_d;
    logic [SP_FRAC_W-1:0] top;
    logic [SP_FRAC_W-1:0] nan_frac;
    logic [SP_FRAC_W:0]   mant;
    logic [4:0]           sh;

    always_comb begin
        sgn      = dp[DP_W-1];
        exp_d    = dp[DP_W-2 -: DP_EXP_W];
        frac_d   = dp[DP_FRAC_W-1:0];
        top      = frac_d[DP_FRAC_W-1 -: SP_FRAC_W];
        nan_frac = top;
        if (frac_d != '0 && top == '0)
            nan_frac[SP_FRAC_W-1] = 1'b1;
        sh   = 5'(11'(DP_NORM_LO) - exp_d);
        mant = {1'b1, top} >> sh;
        if (exp_d == '1)
            sp = {sgn, {SP_EXP_W{1'b1}}, nan_frac};
        else if (exp_d > 11'(DP_NORM_HI))
            sp = {sgn, 8'(SP_EMAX), {SP_FRAC_W{1'b1}}};
        else if (exp_d >= 11'(DP_NORM_LO))
            sp = {sgn, 8'(exp_d - 11'(REBIAS)), top};
        else if (exp_d >= 11'(DP_SUB_LO))
            sp = {sgn, {SP_EXP_W{1'b0}}, mant[SP_FRAC_W-1:0]};
        else
            sp = {sgn, {(SP_W-1){1'b0}}};
    end
endmodule

// File: rtl/fpimm_exec.sv
module fpimm_exec
    import fpimm_pkg::*;
#(
    parameter logic [5:0] PRI_OPC  = 6'd22,
    parameter logic [4:0] XO_SET   = 5'd2,
    parameter logic [4:0] XO_PATCH = 5'd3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic [INSTR_W-1:0]  issue_instr,
    input  logic [DP_W-1:0]     issue_reg,
    output logic                wb_valid,
    output logic [IDX_W-1:0]    wb_idx,
    output logic [DP_W-1:0]     wb_data,
    output logic                illegal
);
    dec_t            dec;
    logic [SP_W-1:0] narrowed;
    logic [SP_W-1:0] src_sp;
    logic [DP_W-1:0] widened;
    state_t          st_d, st_q;

    fpimm_decode #(
        .PRI_OPC (PRI_OPC),
        .XO_SET  (XO_SET),
        .XO_PATCH(XO_PATCH)
    ) dec_i (
        .instr(issue_instr),
        .dec  (dec)
    );

    fpimm_narrow narrow_i (
        .dp(issue_reg),
        .sp(narrowed)
    );

    always_comb begin
        if (dec.op == OP_PATCH)
            src_sp = {narrowed[SP_W-1:IMM_W], dec.imm};
        else
            src_sp = {dec.imm, {(SP_W-IMM_W){1'b0}}};
    end

    fpimm_widen widen_i (
        .sp(src_sp),
        .dp(widened)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wb_valid = issue_valid && (dec.op != OP_NONE);
        st_d.illegal  = issue_valid && (dec.op == OP_NONE);
        if (issue_valid && dec.op != OP_NONE) begin
            st_d.wb_idx  = dec.idx;
            st_d.wb_data = widened;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_valid = st_q.wb_valid;
    assign wb_idx   = st_q.wb_idx;
    assign wb_data  = st_q.wb_data;
    assign illegal  = st_q.illegal;
endmodule

// File: rtl/fpimm_chk.sv
module fpimm_chk
    import fpimm_pkg::*;
#(
    parameter logic [5:0] PRI_OPC  = 6'd22,
    parameter logic [4:0] XO_SET   = 5'd2,
    parameter logic [4:0] XO_PATCH = 5'd3
) (
    input logic               clk,
    input logic               rst,
    input logic               issue_valid,
    input logic [INSTR_W-1:0] issue_instr,
    input logic               wb_valid,
    input logic [IDX_W-1:0]   wb_idx,
    input logic [DP_W-1:0]    wb_data,
    input logic               illegal
);
    logic is_set;
    logic known;

    assign is_set = issue_valid && issue_instr[31:26] == PRI_OPC && issue_instr[5:1] == XO_SET;
    assign known  = issue_instr[31:26] == PRI_OPC &&
                    (issue_instr[5:1] == XO_SET || issue_instr[5:1] == XO_PATCH);

    // R11
    reset_clear_chk: assert property (@(posedge clk) rst |=> !wb_valid && !illegal);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !wb_valid && !illegal);

    // R9
    accept_wb_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid && known |=> wb_valid && !illegal);

    // R9
    wb_index_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_idx == $past(issue_instr[25:21]));

    // R10
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !known |=> illegal && !wb_valid);

    // R2
    set_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && $past(is_set) |-> wb_data[28:0] == '0);

    // R10
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_valid, illegal}));
endmodule

bind fpimm_exec fpimm_chk #(
    .PRI_OPC (PRI_OPC),
    .XO_SET  (XO_SET),
    .XO_PATCH(XO_PATCH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_valid(issue_valid),
    .issue_instr(issue_instr),
    .wb_valid   (wb_valid),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .illegal    (illegal)
);

// File: tb/fpimm_exec_tb.sv
`timescale 1ns/1ps
module fpimm_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic [63:0] issue_reg = '0;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fpimm_exec dut_i (
        .clk        (clk),
        .rst        (rst),
        .issue_valid(issue_valid),
        .issue_instr(issue_instr),
        .issue_reg  (issue_reg),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .illegal    (illegal)
    );

    function automatic logic [31:0] mk(input logic [5:0] pri, input logic [4:0] xo,
                                       input logic [4:0] idx, input logic [15:0] imm);
        return {pri, idx, imm[5:1], imm[15:6], xo, imm[0]};
    endfunction

    // exact FP32 value as FP64 bits, by real arithmetic
    function automatic logic [63:0] ref_widen(input logic [31:0] w);
        real r;
        int  p;
        logic [63:0] b;
        if (w[30:23] == 8'hFF)
            return {w[31], 11'h7FF, w[22:0], 29'h0};
        if (w[30:23] == 8'h00) begin
            r = real'(w[22:0]);
            p = -149;
        end else begin
            r = real'({1'b1, w[22:0]});
            p = int'(w[30:23]) - 150;
        end
        for (int i = 0; i < p; i++) r = r * 2.0;
        for (int i = 0; i > p; i--) r = r / 2.0;
        b = $realtobits(r);
        b[63] = w[31];
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [63:0] rv, input bit legal,
                       input logic [63:0] exp, input string req);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_instr = ins;
        issue_reg   = rv;
        @(posedge clk);
        #1;
        chk(wb_valid == legal && illegal == !legal, req, {62'b0, wb_valid, illegal}, {62'b0, legal, !legal});
        if (legal) begin
            chk(wb_idx == ins[25:21], "R9", 64'(wb_idx), 64'(ins[25:21]));
            chk(wb_data == exp, req, wb_data, exp);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(!wb_valid && !illegal, "R12", {62'b0, wb_valid, illegal}, 64'b0);
    endtask

    task automatic set_op(input logic [15:0] imm, input string req);
        logic [4:0] idx = 5'($urandom);
        run(mk(6'd22, 5'd2, idx, imm), 64'($urandom), 1'b1, ref_widen({imm, 16'h0}), req);
    endtask

    task automatic patch_op(input logic [63:0] rv, input logic [31:0] narrowed,
                            input logic [15:0] imm, input string req);
        logic [4:0] idx = 5'($urandom);
        run(mk(6'd22, 5'd3, idx, imm), rv, 1'b1, ref_widen({narrowed[31:16], imm}), req);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk(!wb_valid && !illegal, "R11", {62'b0, wb_valid, illegal}, 64'b0);
        @(negedge clk);
        rst = 1'b0;

        // directed set-form values
        run(mk(6'd22, 5'd2, 5'd4, 16'h0000), '0, 1, 64'h0000000000000000, "R3");
        run(mk(6'd22, 5'd2, 5'd4, 16'h8000), '0, 1, 64'h8000000000000000, "R3");
        run(mk(6'd22, 5'd2, 5'd4, 16'h3F80), '0, 1, 64'h3FF0000000000000, "R2");
        run(mk(6'd22, 5'd2, 5'd7, 16'hBFC0), '0, 1, 64'hBFF8000000000000, "R2");
        run(mk(6'd22, 5'd2, 5'd9, 16'h7F80), '0, 1, 64'h7FF0000000000000, "R4");
        run(mk(6'd22, 5'd2, 5'd9, 16'hFF80), '0, 1, 64'hFFF0000000000000, "R4");
        run(mk(6'd22, 5'd2, 5'd1, 16'h7FC0), '0, 1, 64'h7FF8000000000000, "R4");
        run(mk(6'd22, 5'd2, 5'd2, 16'h3FFF), '0, 1, 64'h3FFFE00000000000, "R2");
        run(mk(6'd22, 5'd2, 5'd3, 16'h0001), '0, 1, ref_widen(32'h00010000), "R5");
        run(mk(6'd22, 5'd2, 5'd3, 16'h807F), '0, 1, ref_widen(32'h807F0000), "R5");
        run(mk(6'd22, 5'd2, 5'd31, 16'h1234), '0, 1, ref_widen(32'h12340000), "R1");

        // set then patch chain
        run(mk(6'd22, 5'd3, 5'd4, 16'h8000), 64'h3FF0000000000000, 1, 64'h3FF0100000000000, "R6");

        // narrowing corner cases
        patch_op(64'h3FF0000000000001, 32'h3F800000, 16'h1234, "R7");
        patch_op(64'h47F0000000000000, 32'h7F7FFFFF, 16'h0000, "R7");
        patch_op(64'hC7F0000000000000, 32'hFF7FFFFF, 16'hABCD, "R7");
        patch_op(64'h37D0000000000000, 32'h00080000, 16'h0005, "R7");
        patch_op(64'h37D8000000000000, 32'h000C0000, 16'h0000, "R7");
        patch_op(64'h8370000000000000, 32'h80000000, 16'h0001, "R7");
        patch_op(64'h7FF0000000000001, 32'h7FC00000, 16'h0000, "R8");
        patch_op(64'hFFF0000000000000, 32'hFF800000, 16'h0000, "R8");

        // unrecognised words
        run(mk(6'd23, 5'd2, 5'd4, 16'h3F80), '0, 0, '0, "R10");
        run(mk(6'd22, 5'd7, 5'd4, 16'h3F80), '0, 0, '0, "R10");
        run(mk(6'd0,  5'd3, 5'd4, 16'h3F80), '0, 0, '0, "R10");

        // random set and exact-roundtrip patch
        for (int k = 0; k < 200; k++) begin
            set_op(16'($urandom), "R2");
        end
        for (int k = 0; k < 200; k++) begin
            logic [31:0] orig = $urandom;
            patch_op(ref_widen(orig), orig, 16'($urandom), "R6");
        end
        for (int k = 0; k < 40; k++) begin
            logic [4:0] xo = 5'($urandom);
            if (xo == 5'd2 || xo == 5'd3) xo = 5'd9;
            run(mk(6'd22, xo, 5'($urandom), 16'($urandom)), '0, 0, '0, "R10");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule